// File: doc/BRIEF.md
# Two-Phase ADC Acquisition Sequencer

This block drives an external multichannel ADC once per control period. It takes three phase voltages and three phase currents, and it splits the acquisition into two group conversions. The voltage group is converted first and the current group second. A one-clock voltages-ready strobe goes out when the voltage group is complete. That strobe comes in the same cycle that the current group is started, so downstream phase-tracking arithmetic can work on the voltages while the currents are still converting. A one-clock currents-ready strobe closes the acquisition.

The ADC is modelled as a plain handshake. The sequencer pulses a start request and names the group to convert (0 = voltages, 1 = currents). While the ADC works it holds busy high and delivers three 13-bit words, each marked by a one-clock data-valid. A group conversion is complete once three words have arrived and busy is low. Each group conversion has a timeout of 700 clocks, which is 7 µs at 100 MHz and leaves margin over the nominal 6 µs. If the timeout expires, the sequencer sets an error flag and goes back to idle. A sample trigger that comes in while an acquisition is running is ignored and counted as an overrun.

Top module: `acq_seq`

## Requirements
- R1: While reset is applied, and right after it, the start request, both ready strobes and the error flag are low, and the sample outputs and the overrun count are zero.
- R2: A trigger seen in idle produces a start request exactly one clock later. The request is one clock wide and has group select 0 (voltages).
- R3: Within a group conversion, the words are stored in arrival order into channels 0, 1 and 2. Channel k sits at bits [13k+12:13k] of its output. Words after the third one, and words that arrive outside a group conversion, are ignored.
- R4: The voltages-ready strobe is one clock wide. It is raised once three voltage words have arrived and busy is low, and it comes in the same cycle as the start request with group select 1 (currents).
- R5: The currents-ready strobe is one clock wide and is raised when the current group completes. The sequencer is then idle, and the voltage outputs still hold the same acquisition.
- R6: Both sample outputs stay unchanged from their ready strobe until the next trigger is accepted.
- R7: A trigger that arrives while an acquisition is running does not restart it. It increments the overrun count, which saturates at its all-ones value.
- R8: If a group conversion is not complete within 700 clocks of waiting, the error flag rises in the next cycle, the sequencer is idle, and no further ready strobe comes. The next accepted trigger clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously inside the block |
| trig_i | input | 1 | Sample trigger pulse |
| adc_start_o | output | 1 | One-clock start request to the ADC |
| adc_grp_o | output | 1 | Group select: 0 voltages, 1 currents |
| adc_busy_i | input | 1 | ADC converting |
| adc_dvalid_i | input | 1 | ADC result word valid |
| adc_data_i | input | 13 | ADC result word |
| volt_o | output | 39 | Voltage samples, channel k at [13k+12:13k] |
| curr_o | output | 39 | Current samples, channel k at [13k+12:13k] |
| volt_rdy_o | output | 1 | One-clock voltages-ready strobe |
| curr_rdy_o | output | 1 | One-clock currents-ready strobe |
| err_o | output | 1 | Timeout error, held until the next accepted trigger |
| ovr_cnt_o | output | 8 | Saturating count of ignored triggers |

## Verification
The sequence is driven by an ADC model with random gaps between words and random tail lengths before busy drops, which shows that completion waits for both the third word and busy low, and not for either one alone. Some conversions send a fourth word, and garbage words are driven in while idle, which shows that the stored channels take only the first three words of a live conversion. Triggers injected in the middle of an acquisition, and a long slow acquisition with a trigger on every busy cycle, separate ignoring a trigger from restarting, and normal counting from saturation. Starving the voltage group and the current group one at a time checks the exact timeout cycle, the missing strobe and the clearing of the flag.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_VSTART = 3'd1,
    ST_VWAIT  = 3'd2,
    ST_CSTART = 3'd3,
    ST_CWAIT  = 3'd4
  } acq_state_e;

  localparam int GRP_VOLT = 0;
  localparam int GRP_CURR = 1;
  localparam int NUM_GRP  = 2;
endpackage

// File: rtl/acq_rst_sync.sv
`timescale 1ns/1ps
module acq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/acq_timer.sv
`timescale 1ns/1ps
module acq_timer #(
  parameter int TMO_CLKS = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = $clog2(TMO_CLKS);
  localparam logic [TW-1:0] LAST = TW'(TMO_CLKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (run_i && (cnt_q != LAST));
    cnt_d  = clr_i ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R8: the count never passes the timeout limit
  p_tmr_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R8: clearing restarts the window from zero
  p_tmr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/acq_bank.sv
`timescale 1ns/1ps
module acq_bank #(
  parameter int CH = 3,
  parameter int DW = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    din_i,
  output logic             full_o,
  output logic [CH*DW-1:0] dout_o
);
  localparam int IW = $clog2(CH + 1);

  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic          take;

  assign full_o = (idx_q == IW'(CH));
  assign take   = wr_i && !full_o;

  always_comb begin
    idx_en = clr_i || take;
    idx_d  = clr_i ? '0 : idx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  for (genvar k = 0; k < CH; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic          slot_en;

    assign slot_en = take && (idx_q == IW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= din_i;
    end

    assign dout_o[k*DW +: DW] = slot_q;
  end

  // R6: the stored samples move only when a word is taken
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(dout_o));

  // R3: the first word of a conversion lands in channel 0
  p_first_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_q == '0) |=> (dout_o[DW-1:0] == $past(din_i)));

  // R3: once full, further words leave the samples untouched
  p_full_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clr_i) |=> $stable(dout_o));
endmodule

// File: rtl/acq_fsm.sv
`timescale 1ns/1ps
module acq_fsm
  import acq_pkg::*;
#(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             busy_i,
  input  logic             dvalid_i,
  input  logic [1:0]       full_i,
  input  logic             tmo_i,
  output logic             start_o,
  output logic             grp_o,
  output logic             tmr_clr_o,
  output logic             tmr_run_o,
  output logic [1:0]       bank_clr_o,
  output logic [1:0]       bank_wr_o,
  output logic             vrdy_o,
  output logic             crdy_o,
  output logic             err_o,
  output logic [OVR_W-1:0] ovr_o
);
  acq_state_e       state_q, state_d;
  logic             vrdy_q, vrdy_d, crdy_q, crdy_d;
  logic             err_q, err_d;
  logic [OVR_W-1:0] ovr_q;
  logic             ovr_en;
  logic             active;

  assign active = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    vrdy_d  = 1'b0;
    crdy_d  = 1'b0;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          state_d = ST_VSTART;
          err_d   = 1'b0;
        end
      end
      ST_VSTART: state_d = ST_VWAIT;
      ST_VWAIT: begin
        if (full_i[GRP_VOLT] && !busy_i) begin
          state_d = ST_CSTART;
          vrdy_d  = 1'b1;
        end else if (tmo_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_CSTART: state_d = ST_CWAIT;
      ST_CWAIT: begin
        if (full_i[GRP_CURR] && !busy_i) begin
          state_d = ST_IDLE;
          crdy_d  = 1'b1;
        end else if (tmo_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ovr_en = trig_i && active && (ovr_q != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vrdy_q  <= 1'b0;
      crdy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vrdy_q  <= vrdy_d;
      crdy_q  <= crdy_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= '0;
    else if (ovr_en) ovr_q <= ovr_q + OVR_W'(1);
  end

  always_comb begin
    start_o              = (state_q == ST_VSTART) || (state_q == ST_CSTART);
    grp_o                = (state_q == ST_CSTART) || (state_q == ST_CWAIT);
    tmr_clr_o            = start_o;
    tmr_run_o            = (state_q == ST_VWAIT) || (state_q == ST_CWAIT);
    bank_clr_o[GRP_VOLT] = (state_q == ST_VSTART);
    bank_clr_o[GRP_CURR] = (state_q == ST_CSTART);
    bank_wr_o[GRP_VOLT]  = (state_q == ST_VWAIT) && dvalid_i;
    bank_wr_o[GRP_CURR]  = (state_q == ST_CWAIT) && dvalid_i;
  end

  assign vrdy_o = vrdy_q;
  assign crdy_o = crdy_q;
  assign err_o  = err_q;
  assign ovr_o  = ovr_q;

  // R2: a start request lasts one clock
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R4: voltages-ready coincides with the current-group start
  p_vrdy_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vrdy_q |-> (start_o && grp_o));

  // R4: voltages-ready lasts one clock
  p_vrdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vrdy_q |=> !vrdy_q);

  // R5: currents-ready is one clock wide and leaves the sequencer idle
  p_crdy_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crdy_q |-> (!active && !start_o));
  p_crdy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crdy_q |=> !crdy_q);

  // R7: a trigger during an acquisition never restarts it
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && active) |=> (state_q != ST_VSTART));

  // R7: an unsaturated overrun count steps by one
  p_ovr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && active && ovr_q != '1) |=> (ovr_q == $past(ovr_q) + OVR_W'(1)));

  // R8: the error flag rises only as the sequencer returns to idle
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!active && !vrdy_q && !crdy_q));
endmodule

// File: rtl/acq_seq.sv
`timescale 1ns/1ps
module acq_seq
  import acq_pkg::*;
#(
  parameter int DW         = 13,
  parameter int CH         = 3,
  parameter int TMO_CLKS   = 700,
  parameter int OVR_W      = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  output logic             adc_start_o,
  output logic             adc_grp_o,
  input  logic             adc_busy_i,
  input  logic             adc_dvalid_i,
  input  logic [DW-1:0]    adc_data_i,
  output logic [CH*DW-1:0] volt_o,
  output logic [CH*DW-1:0] curr_o,
  output logic             volt_rdy_o,
  output logic             curr_rdy_o,
  output logic             err_o,
  output logic [OVR_W-1:0] ovr_cnt_o
);
  logic               rst_sync_n;
  logic               tmr_clr, tmr_run, tmo;
  logic [1:0]         bank_clr, bank_wr, bank_full;
  logic [CH*DW-1:0]   bank_dout [NUM_GRP];

  acq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  acq_fsm #(.OVR_W(OVR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig_i     (trig_i),
    .busy_i     (adc_busy_i),
    .dvalid_i   (adc_dvalid_i),
    .full_i     (bank_full),
    .tmo_i      (tmo),
    .start_o    (adc_start_o),
    .grp_o      (adc_grp_o),
    .tmr_clr_o  (tmr_clr),
    .tmr_run_o  (tmr_run),
    .bank_clr_o (bank_clr),
    .bank_wr_o  (bank_wr),
    .vrdy_o     (volt_rdy_o),
    .crdy_o     (curr_rdy_o),
    .err_o      (err_o),
    .ovr_o      (ovr_cnt_o)
  );

  acq_timer #(.TMO_CLKS(TMO_CLKS)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .expired_o (tmo)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    acq_bank #(.CH(CH), .DW(DW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr_i  (bank_clr[g]),
      .wr_i   (bank_wr[g]),
      .din_i  (adc_data_i),
      .full_o (bank_full[g]),
      .dout_o (bank_dout[g])
    );
  end

  assign volt_o = bank_dout[GRP_VOLT];
  assign curr_o = bank_dout[GRP_CURR];

  // R6: voltage samples are frozen while the current group converts
  p_volt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adc_grp_o && !adc_start_o) |=> $stable(volt_o));

  // R2: group select is 0 on the first start of an acquisition
  p_first_grp_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adc_start_o && !volt_rdy_o) |-> !adc_grp_o);
endmodule

// File: tb/sim_acq_seq.sv
`timescale 1ns/1ps
module sim_acq_seq;
  localparam int DW = 13;
  localparam int CH = 3;
  localparam int TMO = 700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic busy = 1'b0;
  logic dvalid = 1'b0;
  logic [DW-1:0] data = '0;
  logic start, grp, vrdy, crdy, err;
  logic [CH*DW-1:0] volt, curr;
  logic [7:0] ovr;

  int n_chk = 0;
  int n_bad = 0;
  int drop_mode = 0;
  int gapmax = 2;
  bit extra = 1'b0;
  int exp_ovr = 0;
  logic [DW-1:0] ev [CH];
  logic [DW-1:0] ec [CH];

  always #2.5 clk = ~clk;

  acq_seq u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig),
    .adc_start_o(start), .adc_grp_o(grp), .adc_busy_i(busy),
    .adc_dvalid_i(dvalid), .adc_data_i(data),
    .volt_o(volt), .curr_o(curr), .volt_rdy_o(vrdy), .curr_rdy_o(crdy),
    .err_o(err), .ovr_cnt_o(ovr)
  );

  function automatic logic [CH*DW-1:0] pack3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    return {c, b, a};
  endfunction

  function automatic int sat_ovr(int n);
    return (n > 255) ? 255 : n;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_conv(bit g);
    logic [DW-1:0] d;
    busy = 1'b1;
    for (int ch = 0; ch < CH; ch++) begin
      @(negedge clk);
      repeat ($urandom_range(0, gapmax)) @(negedge clk);
      d = DW'($urandom);
      if (g) ec[ch] = d; else ev[ch] = d;
      dvalid = 1'b1; data = d;
      @(negedge clk);
      dvalid = 1'b0;
    end
    if (extra) begin
      dvalid = 1'b1; data = DW'($urandom);
      @(negedge clk);
      dvalid = 1'b0;
    end
    repeat ($urandom_range(0, gapmax)) @(negedge clk);
    busy = 1'b0;
  endtask

  // ADC model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && start) begin
        if (!((drop_mode == 1 && !grp) || (drop_mode == 2 && grp)))
          run_conv(grp);
      end
    end
  end

  task automatic fire();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(start && !grp, "R2 start pulse voltages", {start, grp}, 2'b10);
    chk(!err, "R8 err cleared by trigger", err, 0);
  endtask

  task automatic run_acq(bit mid, output bit got_v, output bit got_c, output bit got_e);
    bit prev_v = 1'b0;
    got_v = 0; got_c = 0; got_e = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      trig = 1'b0;
      if (vrdy) begin
        chk(!prev_v, "R4 vrdy one clock", 1, 0);
        chk(volt == pack3(ev[0], ev[1], ev[2]), "R3 R4 voltage data", volt, pack3(ev[0], ev[1], ev[2]));
        chk(start && grp, "R4 vrdy with current start", {start, grp}, 2'b11);
        got_v = 1;
      end
      prev_v = vrdy;
      if (crdy) begin
        chk(curr == pack3(ec[0], ec[1], ec[2]), "R3 R5 current data", curr, pack3(ec[0], ec[1], ec[2]));
        chk(volt == pack3(ev[0], ev[1], ev[2]), "R5 voltage held", volt, pack3(ev[0], ev[1], ev[2]));
        got_c = 1;
        break;
      end
      if (err) begin
        got_e = 1;
        break;
      end
      if (mid && i == 2) begin
        trig = 1'b1;
        exp_ovr++;
      end
    end
    trig = 1'b0;
  endtask

  task automatic idle_check(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i == 0) chk(!crdy && !start, "R5 strobe ends, idle", {crdy, start}, 0);
    end
    chk(volt == pack3(ev[0], ev[1], ev[2]), "R6 voltage stable", volt, pack3(ev[0], ev[1], ev[2]));
    chk(curr == pack3(ec[0], ec[1], ec[2]), "R6 current stable", curr, pack3(ec[0], ec[1], ec[2]));
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit gv, gc, ge;
    int seed_dummy;
    int cnt;
    seed_dummy = $urandom(32'h5eed);
    for (int k = 0; k < CH; k++) begin ev[k] = '0; ec[k] = '0; end

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!start && !vrdy && !crdy && !err, "R1 strobes in reset", {start, vrdy, crdy, err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(volt == '0 && curr == '0, "R1 samples zero", {volt[31:0], curr[31:0]}, 0);
    chk(ovr == 0 && !err && !start, "R1 idle after reset", {ovr, err, start}, 0);

    // directed: clean acquisition
    gapmax = 0; extra = 0;
    fire();
    run_acq(0, gv, gc, ge);
    chk(gv && gc && !ge, "R4 R5 basic acquisition", {gv, gc, ge}, 3'b110);
    idle_check(3);

    // R3 words outside a conversion are ignored
    @(negedge clk); dvalid = 1'b1; data = 13'h1abc;
    @(negedge clk); dvalid = 1'b0;
    idle_check(2);

    // random acquisitions
    for (int it = 0; it < 30; it++) begin
      bit mid;
      gapmax = $urandom_range(0, 4);
      extra  = 1'($urandom_range(0, 1));
      mid    = 1'($urandom_range(0, 1));
      fire();
      run_acq(mid, gv, gc, ge);
      chk(gv && gc && !ge, "R4 R5 random acquisition", {gv, gc, ge}, 3'b110);
      chk(ovr == 8'(sat_ovr(exp_ovr)), "R7 overrun count", ovr, sat_ovr(exp_ovr));
      idle_check($urandom_range(1, 6));
    end

    // R8 voltage-group timeout, exact cycle
    drop_mode = 1;
    fire();
    repeat (TMO) @(negedge clk);
    chk(!err && !vrdy, "R8 no error before limit", {err, vrdy}, 0);
    @(negedge clk);
    chk(err && !vrdy && !start, "R8 error at limit", {err, vrdy, start}, 3'b100);
    repeat (3) @(negedge clk);
    chk(err && !crdy, "R8 error held, no strobe", {err, crdy}, 2'b10);

    // recovery clears error
    drop_mode = 0; gapmax = 1; extra = 0;
    fire();
    run_acq(0, gv, gc, ge);
    chk(gv && gc && !ge, "R8 recovery acquisition", {gv, gc, ge}, 3'b110);
    idle_check(2);

    // R8 current-group timeout
    drop_mode = 2;
    fire();
    run_acq(0, gv, gc, ge);
    chk(gv && !gc && ge, "R8 current timeout", {gv, gc, ge}, 3'b101);
    @(negedge clk);
    chk(err && !crdy && !start, "R8 idle after current timeout", {err, crdy, start}, 3'b100);
    drop_mode = 0;

    // R7 saturation: trigger on every busy cycle of a slow acquisition
    gapmax = 150; extra = 0;
    fire();
    cnt = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #1;
      if (crdy) break;
      trig = busy;
      if (busy) cnt++;
    end
    trig = 1'b0;
    exp_ovr = sat_ovr(exp_ovr + cnt);
    repeat (2) @(negedge clk);
    chk(ovr == 8'(exp_ovr), "R7 overrun saturation", ovr, exp_ovr);
    chk(curr == pack3(ec[0], ec[1], ec[2]), "R7 acquisition unaffected", curr, pack3(ec[0], ec[1], ec[2]));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule